// File: doc/BRIEF.md
# Audio DMA Address Generator

This block generates memory addresses for one audio sample stream moving between a local FIFO and system memory. Software programs three things: a buffer start address, an end (protection) address, and a limit code. The limit code sets a power-of-two interrupt period. When transfers are enabled, the block waits until the FIFO can take or supply a whole threshold's worth of dwords. It then requests a burst from the memory bus, starting at the current pointer. The pointer moves forward one dword on each acknowledged transfer.

The buffer is circular. Once the pointer would reach the protection address, it reloads the start address. Each time the pointer passes an address aligned to the selected period, a status flag is set. That flag drives an interrupt line, gated by an enable bit. Software reads the live pointer to find its position in the buffer. A masked-write control register starts and stops the stream without a read-modify-write.

Top module: `audio_dma_addrgen`

## Requirements
- R1: After reset the pointer (offset 0x1C) reads 0, control (0x10) and status (0x14) read 0, `bus_req` is low and `irq` is low.
- R2: Registers are at these byte offsets: start address 0x00, protection address 0x04, page/limit 0x08, burst configuration 0x0C, control 0x10, status 0x14, interrupt enable 0x18, live pointer 0x1C (read-only). Start and protection addresses are dword aligned, so bits 1:0 read back as 0.
- R3: A control write updates bit n of bits 15:0 only when bit n+16 of the written word is 1. Bit 0 is transfer enable. Bit 1 is direction: 1 means the FIFO fills memory, 0 means memory fills the FIFO. A write with mask bits 0 leaves control unchanged and starts nothing.
- R4: Page/limit bits 7:4 hold the limit code. Bit 11 (address translation) is not stored and reads back 0.
- R5: Burst configuration bits 2:0 hold a burst code. The requested `bus_len` is never 0 and never more than 2^code dwords.
- R6: Burst configuration bits 5:4 give a threshold of 1, 4, 8 or 16 dwords for codes 0 to 3. With direction 1 the threshold is compared with `fifo_level`. With direction 0 it is compared with FIFO_DEPTH minus `fifo_level`. A request is raised only when the compared value is at least the threshold.
- R7: A burst is cut short so that it never passes the protection address. When the limit code is nonzero, it also never passes the next 2^(5+limit)-byte boundary.
- R8: `bus_req` holds with a stable `bus_addr` (the pointer) and `bus_len` until `bus_gnt`. After the grant, each `dw_ack` advances the pointer by 4. The burst ends after `bus_len` acknowledgements.
- R9: When the advanced pointer would be at or beyond the protection address, the pointer loads the start address instead.
- R10: With a nonzero limit code, status bit 0 is set on the clock edge that completes a dword whose following address has its low 5+limit bits all zero. Limit code 0 never sets it. Reloading the start address never sets it on its own.
- R11: Writing 1 to status bit 0 clears it. Writing 0 leaves it set. `irq` is status bit 0 AND enable bit 0.
- R12: Clearing enable withdraws a request that has not been granted. A granted burst completes; after it, the pointer holds and no request is raised. Setting enable from the idle state reloads the pointer from the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| fifo_level | input | $clog2(FIFO_DEPTH+1) | Valid dwords held in the local FIFO |
| bus_req | output | 1 | Burst request |
| bus_addr | output | AW | Burst start byte address |
| bus_len | output | 8 | Burst length in dwords |
| bus_gnt | input | 1 | Burst grant, sampled while bus_req is high |
| dw_ack | input | 1 | One dword of the granted burst completed |
| irq | output | 1 | Boundary interrupt |

## Verification
The assertions check four things on every cycle. A pending request holds its address and length until granted. Every requested length stays within the burst code. No request spans the protection address or a limit boundary. The status flag only rises on a cycle that acknowledged a dword. The bench scenarios cover what needs a history of register writes: threshold gating in each direction, wrap-around to the start address, the exact acknowledgement that raises the flag, write-one-to-clear, and masked control writes. They also cover a burst that finishes after disable, followed by a pointer reload on re-enable.

// File: rtl/adg_pkg.sv
// Shared constants and types for the audio DMA address generator.
// Assumes a 32-bit register bus addressed by byte offset.
package adg_pkg;
    localparam logic [4:0] OFS_BASE = 5'h00;
    localparam logic [4:0] OFS_PROT = 5'h04;
    localparam logic [4:0] OFS_PAGE = 5'h08;
    localparam logic [4:0] OFS_CFG  = 5'h0C;
    localparam logic [4:0] OFS_CTRL = 5'h10;
    localparam logic [4:0] OFS_ISR  = 5'h14;
    localparam logic [4:0] OFS_IER  = 5'h18;
    localparam logic [4:0] OFS_PTR  = 5'h1C;

    localparam int MAX_BURST_LOG = 7;
    localparam int LENW = MAX_BURST_LOG + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_REQ,
        ST_XFER
    } walk_state_e;
endpackage

// File: rtl/adg_regs.sv
// Register file: start/protection addresses, limit code, burst config,
// masked-write control, W1C status and interrupt enable, pointer readback.
// Assumes AW <= 32 and that bnd_hit is a single-cycle pulse.
module adg_regs
    import adg_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [4:0]    addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    input  logic [AW-1:0] ptr,
    input  logic          bnd_hit,
    output logic [AW-1:0] base,
    output logic [AW-1:0] prot,
    output logic [3:0]    limit,
    output logic [2:0]    bcode,
    output logic [1:0]    tcode,
    output logic          en,
    output logic          dir,
    output logic          irq
);
    logic isr_q;
    logic ier_q;
    logic clr_isr;

    assign clr_isr = we && (addr == OFS_ISR) && wdata[0];

    // Configuration and control registers, control uses per-bit mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base  <= '0;
            prot  <= '0;
            limit <= '0;
            bcode <= '0;
            tcode <= '0;
            en    <= 1'b0;
            dir   <= 1'b0;
            ier_q <= 1'b0;
        end else if (we) begin
            case (addr)
                OFS_BASE: base <= {wdata[AW-1:2], 2'b00};
                OFS_PROT: prot <= {wdata[AW-1:2], 2'b00};
                OFS_PAGE: limit <= wdata[7:4];
                OFS_CFG: begin
                    bcode <= wdata[2:0];
                    tcode <= wdata[5:4];
                end
                OFS_CTRL: begin
                    if (wdata[16]) en  <= wdata[0];
                    if (wdata[17]) dir <= wdata[1];
                end
                OFS_IER: ier_q <= wdata[0];
                default: ;
            endcase
        end
    end

    // Status flag: a new boundary hit wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= 1'b0;
        else        isr_q <= bnd_hit | (isr_q & ~clr_isr);
    end

    assign irq = isr_q & ier_q;

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_BASE: rdata = 32'(base);
            OFS_PROT: rdata = 32'(prot);
            OFS_PAGE: rdata = {24'd0, limit, 4'd0};
            OFS_CFG:  rdata = {26'd0, tcode, 1'b0, bcode};
            OFS_CTRL: rdata = {30'd0, dir, en};
            OFS_ISR:  rdata = {31'd0, isr_q};
            OFS_IER:  rdata = {31'd0, ier_q};
            OFS_PTR:  rdata = 32'(ptr);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/adg_burst_calc.sv
// Combinational burst sizing and threshold test. The burst is the
// smallest of the configured length, the dwords left before the
// protection address and the dwords left before the next limit boundary.
// Assumes FIFO_DEPTH >= 16 and limit codes up to 15 fit in AW bits.
module adg_burst_calc
    import adg_pkg::*;
#(
    parameter int AW         = 32,
    parameter int FIFO_DEPTH = 64,
    localparam int LVLW      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic [AW-1:0]   ptr,
    input  logic [AW-1:0]   prot,
    input  logic [3:0]      limit,
    input  logic [2:0]      bcode,
    input  logic [1:0]      tcode,
    input  logic            dir,
    input  logic [LVLW-1:0] level,
    output logic [LENW-1:0] len,
    output logic [AW-1:0]   lim_mask,
    output logic            ready
);
    logic [AW-1:0]   rng;
    logic [AW-1:0]   to_bnd;
    logic [AW-1:0]   to_prot;
    logic [AW-1:0]   cap;
    logic [AW-1:0]   pick;
    logic [LVLW-1:0] avail;
    logic [4:0]      thr;

    // Distance limits and the resulting burst length.
    always_comb begin
        rng      = {{(AW-1){1'b0}}, 1'b1} << (5 + 32'(limit));
        lim_mask = rng - 1'b1;
        to_bnd   = (rng - (ptr & lim_mask)) >> 2;
        to_prot  = (prot > ptr) ? ((prot - ptr) >> 2) : {{(AW-1){1'b0}}, 1'b1};
        cap      = {{(AW-1){1'b0}}, 1'b1} << bcode;
        pick     = cap;
        if (to_prot < pick) pick = to_prot;
        if ((limit != 4'd0) && (to_bnd < pick)) pick = to_bnd;
        len = pick[LENW-1:0];
    end

    // Threshold on valid dwords (dir=1) or free dwords (dir=0).
    always_comb begin
        avail = dir ? level : (LVLW'(FIFO_DEPTH) - level);
        case (tcode)
            2'd0:    thr = 5'd1;
            2'd1:    thr = 5'd4;
            2'd2:    thr = 5'd8;
            default: thr = 5'd16;
        endcase
        ready = (32'(avail) >= 32'(thr));
    end
endmodule

// File: rtl/adg_walker.sv
// Pointer sequencer: waits for threshold, requests a burst, advances
// the pointer on each acknowledged dword, wraps at the protection
// address and pulses bnd_hit on each limit boundary crossing.
// Assumes dw_ack is only asserted for a granted burst.
module adg_walker
    import adg_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   prot,
    input  logic [3:0]      limit,
    input  logic [AW-1:0]   lim_mask,
    input  logic [LENW-1:0] calc_len,
    input  logic            calc_ready,
    input  logic            bus_gnt,
    input  logic            dw_ack,
    output logic [AW-1:0]   ptr,
    output logic            bus_req,
    output logic [LENW-1:0] bus_len,
    output logic            bnd_hit
);
    walk_state_e     st_q;
    logic [LENW-1:0] remain_q;
    logic [AW-1:0]   nxt;
    logic            bnd_next;

    assign nxt      = ptr + AW'(4);
    assign bnd_next = (limit != 4'd0) && ((nxt & lim_mask) == '0);
    assign bnd_hit  = (st_q == ST_XFER) && dw_ack && bnd_next;
    assign bus_req  = (st_q == ST_REQ);

    // State, pointer and burst bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            ptr      <= '0;
            remain_q <= '0;
            bus_len  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (en) begin
                        ptr  <= base;
                        st_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!en) begin
                        st_q <= ST_IDLE;
                    end else if (calc_ready) begin
                        bus_len <= calc_len;
                        st_q    <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (!en) begin
                        st_q <= ST_IDLE;
                    end else if (bus_gnt) begin
                        remain_q <= bus_len;
                        st_q     <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (dw_ack) begin
                        ptr      <= (nxt >= prot) ? base : nxt;
                        remain_q <= remain_q - 1'b1;
                        if (remain_q == LENW'(1)) st_q <= en ? ST_WAIT : ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/audio_dma_addrgen.sv
// Top level: register file, burst sizing and pointer sequencer for one
// circular audio DMA stream. Assumes software does not change the
// start or protection address while transfers are enabled.
module audio_dma_addrgen
    import adg_pkg::*;
#(
    parameter int AW         = 32,
    parameter int FIFO_DEPTH = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_we,
    input  logic [4:0]                      reg_addr,
    input  logic [31:0]                     reg_wdata,
    output logic [31:0]                     reg_rdata,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
    output logic                            bus_req,
    output logic [AW-1:0]                   bus_addr,
    output logic [LENW-1:0]                 bus_len,
    input  logic                            bus_gnt,
    input  logic                            dw_ack,
    output logic                            irq
);
    logic [AW-1:0]   base_q;
    logic [AW-1:0]   prot_q;
    logic [3:0]      limit_q;
    logic [2:0]      bcode_q;
    logic [1:0]      tcode_q;
    logic            ctrl_en;
    logic            ctrl_dir;
    logic [AW-1:0]   ptr_q;
    logic            bnd_hit;
    logic [LENW-1:0] calc_len;
    logic [AW-1:0]   lim_mask;
    logic            calc_ready;

    adg_regs #(.AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ptr(ptr_q), .bnd_hit(bnd_hit),
        .base(base_q), .prot(prot_q), .limit(limit_q), .bcode(bcode_q),
        .tcode(tcode_q), .en(ctrl_en), .dir(ctrl_dir), .irq(irq)
    );

    adg_burst_calc #(.AW(AW), .FIFO_DEPTH(FIFO_DEPTH)) calc_i (
        .ptr(ptr_q), .prot(prot_q), .limit(limit_q), .bcode(bcode_q),
        .tcode(tcode_q), .dir(ctrl_dir), .level(fifo_level),
        .len(calc_len), .lim_mask(lim_mask), .ready(calc_ready)
    );

    adg_walker #(.AW(AW)) walk_i (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .base(base_q), .prot(prot_q),
        .limit(limit_q), .lim_mask(lim_mask), .calc_len(calc_len),
        .calc_ready(calc_ready), .bus_gnt(bus_gnt), .dw_ack(dw_ack),
        .ptr(ptr_q), .bus_req(bus_req), .bus_len(bus_len), .bnd_hit(bnd_hit)
    );

    assign bus_addr = ptr_q;
endmodule

// File: rtl/adg_chk.sv
// Protocol and range checks for audio_dma_addrgen, bound to the top.
module adg_chk
    import adg_pkg::*;
#(
    parameter int AW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            bus_req,
    input logic            bus_gnt,
    input logic [AW-1:0]   bus_addr,
    input logic [LENW-1:0] bus_len,
    input logic [AW-1:0]   prot,
    input logic [3:0]      limit,
    input logic [2:0]      bcode,
    input logic            flag,
    input logic            dw_ack
);
    logic [AW-1:0] rng;
    logic [AW:0]   end_addr;
    logic [AW:0]   off_end;

    // Independent span arithmetic for the range checks.
    always_comb begin
        rng      = {{(AW-1){1'b0}}, 1'b1} << (5 + 32'(limit));
        end_addr = {1'b0, bus_addr} + (AW+1)'({bus_len, 2'b00});
        off_end  = (AW+1)'(bus_addr & (rng - 1'b1)) + (AW+1)'({bus_len, 2'b00});
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt && en |=> bus_req && $stable(bus_addr) && $stable(bus_len));

    // R5
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_len != '0) && (32'(bus_len) <= (32'd1 << bcode)));

    // R7
    prot_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && (bus_addr < prot) |-> end_addr <= {1'b0, prot});

    // R7
    bnd_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && (limit != 4'd0) |-> off_end <= {1'b0, rng});

    // R10
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(dw_ack));
endmodule

bind audio_dma_addrgen adg_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_len(bus_len),
    .prot(prot_q), .limit(limit_q), .bcode(bcode_q), .flag(regs_i.isr_q),
    .dw_ack(dw_ack)
);

// File: tb/audio_dma_addrgen_tb_top.sv
`timescale 1ns/1ps
module audio_dma_addrgen_tb_top;
    localparam int AW = 32;
    localparam int DEPTH = 64;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] prot;
        logic [3:0]  lim;
        logic [2:0]  bc;
        logic [1:0]  tc;
        logic        dir;
        logic [6:0]  lvl;
        logic [7:0]  len;
    } vec_t;

    localparam vec_t TV [6] = '{
        '{32'h1000, 32'h1100, 4'd1, 3'd7, 2'd0, 1'b1, 7'd1,  8'd16},
        '{32'h1000, 32'h1100, 4'd0, 3'd7, 2'd0, 1'b1, 7'd1,  8'd64},
        '{32'h1004, 32'h2000, 4'd1, 3'd3, 2'd0, 1'b1, 7'd1,  8'd8},
        '{32'h103C, 32'h2000, 4'd1, 3'd7, 2'd0, 1'b1, 7'd1,  8'd1},
        '{32'h2000, 32'h2010, 4'd0, 3'd0, 2'd0, 1'b1, 7'd1,  8'd1},
        '{32'h4000, 32'h5000, 4'd0, 3'd2, 2'd1, 1'b0, 7'd60, 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [6:0]  fifo_level = '0;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic [7:0]  bus_len;
    logic        bus_gnt = 1'b0;
    logic        dw_ack = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    audio_dma_addrgen #(.AW(AW), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_level(fifo_level),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_len(bus_len),
        .bus_gnt(bus_gnt), .dw_ack(dw_ack), .irq(irq)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 20; i++) begin
            if (bus_req) break;
            @(negedge clk);
        end
    endtask

    task automatic run_acks(input int n);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        dw_ack = 1'b1;
        repeat (n) @(negedge clk);
        dw_ack = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 req", 32'(bus_req), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(5'h1C, rv); chk("R1 ptr", rv, 0);
        rd(5'h10, rv); chk("R1 ctrl", rv, 0);
        rd(5'h14, rv); chk("R1 isr", rv, 0);
        @(negedge clk);

        // Table: first burst address and length per configuration (R5 R6 R7)
        for (int k = 0; k < 6; k++) begin
            wr(5'h00, TV[k].base);
            wr(5'h04, TV[k].prot);
            wr(5'h08, {24'd0, TV[k].lim, 4'd0});
            wr(5'h0C, {26'd0, TV[k].tc, 1'b0, TV[k].bc});
            fifo_level = TV[k].lvl;
            wr(5'h10, {16'h0003, 14'd0, TV[k].dir, 1'b1});
            wait_req();
            chk("R7 table req", 32'(bus_req), 1);
            chk("R8 table addr", bus_addr, TV[k].base);
            chk("R5 R7 table len", 32'(bus_len), 32'(TV[k].len));
            wr(5'h10, 32'h0001_0000);
            @(negedge clk);
            chk("R12 withdraw", 32'(bus_req), 0);
        end

        // R10 boundary flag timing, R11 irq
        wr(5'h00, 32'h1000); wr(5'h04, 32'h1100); wr(5'h08, 32'h10);
        wr(5'h0C, 32'h7); wr(5'h18, 32'h1); fifo_level = 7'd1;
        wr(5'h10, 32'h0003_0003);
        wait_req();
        bus_gnt = 1'b1; @(negedge clk); bus_gnt = 1'b0;
        dw_ack = 1'b1;
        repeat (15) @(negedge clk);
        rd(5'h14, rv); chk("R10 before boundary", rv, 0);
        @(negedge clk);
        dw_ack = 1'b0;
        rd(5'h14, rv); chk("R10 at boundary", rv, 1);
        chk("R11 irq set", 32'(irq), 1);
        rd(5'h1C, rv); chk("R8 ptr advance", rv, 32'h1040);
        @(negedge clk);
        // R11 write-one-to-clear
        wr(5'h14, 32'h0); rd(5'h14, rv); chk("R11 w0 keeps", rv, 1);
        @(negedge clk);
        wr(5'h14, 32'h1); rd(5'h14, rv); chk("R11 w1 clears", rv, 0);
        chk("R11 irq clear", 32'(irq), 0);
        @(negedge clk);
        wr(5'h18, 32'h0);
        wait_req();
        chk("R8 next addr", bus_addr, 32'h1040);
        run_acks(16);
        rd(5'h14, rv); chk("R10 second boundary", rv, 1);
        chk("R11 irq masked", 32'(irq), 0);
        @(negedge clk);
        wr(5'h18, 32'h1);
        chk("R11 irq enabled", 32'(irq), 1);
        wr(5'h14, 32'h1);

        // R9 wrap to start, reload raises no flag
        wr(5'h10, 32'h0001_0000);
        wr(5'h00, 32'h3008); wr(5'h04, 32'h3020);
        wr(5'h10, 32'h0001_0001);
        wait_req();
        chk("R7 prot len", 32'(bus_len), 6);
        run_acks(6);
        rd(5'h1C, rv); chk("R9 wrap ptr", rv, 32'h3008);
        rd(5'h14, rv); chk("R10 no flag on reload", rv, 0);
        @(negedge clk);

        // R12 disable during a granted burst
        wr(5'h10, 32'h0001_0000);
        wr(5'h00, 32'h5000); wr(5'h04, 32'h6000); wr(5'h08, 32'h0); wr(5'h0C, 32'h2);
        wr(5'h10, 32'h0001_0001);
        wait_req();
        run_acks(1);
        wr(5'h10, 32'h0001_0000);
        dw_ack = 1'b1; repeat (3) @(negedge clk); dw_ack = 1'b0;
        repeat (4) @(negedge clk);
        chk("R12 no req after stop", 32'(bus_req), 0);
        rd(5'h1C, rv); chk("R12 ptr holds", rv, 32'h5010);
        @(negedge clk);
        wr(5'h10, 32'h0001_0001);
        @(negedge clk);
        rd(5'h1C, rv); chk("R12 reload base", rv, 32'h5000);
        @(negedge clk);
        wait_req();
        chk("R12 req from base", bus_addr, 32'h5000);

        // R3 masked control writes
        wr(5'h10, 32'h0003_0000);
        wr(5'h10, 32'h0000_0001);
        rd(5'h10, rv); chk("R3 unmasked write ignored", rv, 0);
        @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R3 no start", 32'(bus_req), 0);
        wr(5'h10, 32'h0002_0003);
        rd(5'h10, rv); chk("R3 dir only", rv, 2);
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R3 still idle", 32'(bus_req), 0);

        // R4 translation bit, R2 alignment
        wr(5'h08, 32'h0810);
        rd(5'h08, rv); chk("R4 page", rv, 32'h10);
        @(negedge clk);
        wr(5'h00, 32'h1003);
        rd(5'h00, rv); chk("R2 base aligned", rv, 32'h1000);
        @(negedge clk);

        // R6 threshold gating
        wr(5'h04, 32'h1100); wr(5'h0C, 32'h30); fifo_level = 7'd15;
        wr(5'h10, 32'h0003_0003);
        repeat (8) @(negedge clk);
        chk("R6 below valid thr", 32'(bus_req), 0);
        fifo_level = 7'd16;
        wait_req();
        chk("R6 valid thr met", 32'(bus_req), 1);
        wr(5'h10, 32'h0003_0000);
        fifo_level = 7'd60;
        wr(5'h10, 32'h0003_0001);
        repeat (8) @(negedge clk);
        chk("R6 below free thr", 32'(bus_req), 0);
        fifo_level = 7'd48;
        wait_req();
        chk("R6 free thr met", 32'(bus_req), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule